// File: doc/BRIEF.md
# Paged Bus Address Window Bridge

This bridge gives a bus master that only decodes a narrow 64 KiB region access to a full 32-bit slave address space. The lower half of the bridge's upstream region holds a page register that software loads with the upper bits of the target address. The upper half is a 32 KiB data window. Every access into the window is turned into one single-beat transaction on a Wishbone-style downstream port. The downstream address is formed from the stored page bits and the low offset bits of the window access.

The upstream side is a simple strobe/acknowledge slave. A page register access completes one cycle after the request. A window access holds the upstream acknowledge back until the downstream slave acknowledges. If the slave stays silent for a parameterised number of cycles, the bridge ends the cycle itself, returning all-ones read data. Downstream address, write data, byte selects and direction are registered when the transaction starts. They stay constant until it ends.

Top module: `paged_window_bridge`

## Requirements
- R1: After reset, the page register reads as zero, no downstream cycle is active, and the upstream acknowledge is low.
- R2: Any upstream access whose offset bit 15 is clear targets the page register. A write stores only data bits [31:15]. A read returns the stored bits with bits [14:0] reading as zero.
- R3: A page register access raises the upstream acknowledge exactly one cycle after the request is sampled, and it starts no downstream cycle.
- R4: An upstream access whose offset bit 15 is set starts one downstream cycle, with address equal to the page bits [31:15] joined with offset bits [14:0].
- R5: For a window write, the downstream port carries the upstream write data, the byte selects unchanged and write direction. For a window read, it carries read direction.
- R6: For a window read, the upstream read data equals the data the downstream slave returned with its acknowledge.
- R7: The upstream acknowledge is a single-cycle pulse. For a window access, it follows either a downstream acknowledge or the timeout.
- R8: If no downstream acknowledge arrives, the downstream cycle stays active for exactly TIMEOUT clock cycles. The bridge then drops it, acknowledges upstream and returns 0xFFFFFFFF as read data.
- R9: While a downstream cycle is active, its address, direction, write data and byte selects do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_stb | input | 1 | Upstream request, held until acknowledged |
| up_we | input | 1 | Upstream write when high |
| up_adr | input | 16 | Upstream byte offset; bit 15 selects the window |
| up_wdata | input | 32 | Upstream write data |
| up_sel | input | 4 | Upstream byte selects |
| up_rdata | output | 32 | Upstream read data, valid with up_ack |
| up_ack | output | 1 | Upstream acknowledge pulse |
| dn_cyc | output | 1 | Downstream cycle active |
| dn_stb | output | 1 | Downstream strobe |
| dn_we | output | 1 | Downstream write when high |
| dn_adr | output | 32 | Downstream full address |
| dn_wdata | output | 32 | Downstream write data |
| dn_sel | output | 4 | Downstream byte selects |
| dn_rdata | input | 32 | Downstream read data |
| dn_ack | input | 1 | Downstream acknowledge |

## Verification
The assertions assume that the upstream master keeps its request and fields steady until it sees the acknowledge, and that it lowers the strobe on the edge that samples the acknowledge. They also assume that the downstream slave raises dn_ack only while dn_stb is high. The bench's master task drops the strobe at the falling edge where it sees the acknowledge. Its slave model answers only strobed cycles, with a random latency, and is silenced on purpose for the timeout cases.

// File: rtl/paged_window_bridge.sv
module paged_window_bridge #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int OFFS_W  = 15,
  parameter int TIMEOUT = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_stb,
  input  logic                up_we,
  input  logic [OFFS_W:0]     up_adr,
  input  logic [DATA_W-1:0]   up_wdata,
  input  logic [DATA_W/8-1:0] up_sel,
  output logic [DATA_W-1:0]   up_rdata,
  output logic                up_ack,
  output logic                dn_cyc,
  output logic                dn_stb,
  output logic                dn_we,
  output logic [ADDR_W-1:0]   dn_adr,
  output logic [DATA_W-1:0]   dn_wdata,
  output logic [DATA_W/8-1:0] dn_sel,
  input  logic [DATA_W-1:0]   dn_rdata,
  input  logic                dn_ack
);
  localparam int PAGE_W = ADDR_W - OFFS_W;
  localparam int TMR_W  = $clog2(TIMEOUT + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  logic [PAGE_W-1:0] page_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              busy_q;

  wire win_hit = up_adr[OFFS_W];
  wire new_req = up_stb && !up_ack && !busy_q;

  assign dn_cyc = busy_q;
  assign dn_stb = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      tmr_q    <= '0;
      busy_q   <= 1'b0;
      up_ack   <= 1'b0;
      up_rdata <= '0;
      dn_we    <= 1'b0;
      dn_adr   <= '0;
      dn_wdata <= '0;
      dn_sel   <= '0;
    end else begin
      up_ack <= 1'b0;
      if (busy_q) begin
        if (dn_ack) begin
          busy_q   <= 1'b0;
          up_ack   <= 1'b1;
          up_rdata <= dn_rdata;
        end else if (tmr_q == TMR_LAST) begin
          busy_q   <= 1'b0;
          up_ack   <= 1'b1;
          up_rdata <= '1;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end else if (new_req) begin
        if (win_hit) begin
          busy_q   <= 1'b1;
          tmr_q    <= '0;
          dn_we    <= up_we;
          dn_adr   <= {page_q, up_adr[OFFS_W-1:0]};
          dn_wdata <= up_wdata;
          dn_sel   <= up_sel;
        end else begin
          up_ack   <= 1'b1;
          up_rdata <= {page_q, {OFFS_W{1'b0}}};
          if (up_we) page_q <= up_wdata[DATA_W-1:OFFS_W];
        end
      end
    end
  end
endmodule

// File: rtl/paged_window_bridge_chk.sv
module paged_window_bridge_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                up_ack,
  input logic                dn_cyc,
  input logic                dn_ack,
  input logic                dn_we,
  input logic [ADDR_W-1:0]   dn_adr,
  input logic [DATA_W-1:0]   dn_wdata,
  input logic [DATA_W/8-1:0] dn_sel
);
  localparam int CNT_W = $clog2(TIMEOUT + 2);
  logic [CNT_W-1:0] act_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) act_cnt <= '0;
    else if (dn_cyc) act_cnt <= act_cnt + 1'b1;
    else act_cnt <= '0;
  end

  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack |=> !up_ack);

  a_r7_win_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ack && $past(dn_cyc)) |-> ($past(dn_ack) || $past(act_cnt) == CNT_W'(TIMEOUT - 1)));

  a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    dn_cyc |-> act_cnt < CNT_W'(TIMEOUT));

  a_r9_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_cyc && $past(dn_cyc)) |-> ($stable(dn_adr) && $stable(dn_we) && $stable(dn_wdata) && $stable(dn_sel)));
endmodule

bind paged_window_bridge paged_window_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .up_ack(up_ack), .dn_cyc(dn_cyc), .dn_ack(dn_ack),
  .dn_we(dn_we), .dn_adr(dn_adr), .dn_wdata(dn_wdata), .dn_sel(dn_sel)
);

// File: tb/paged_window_bridge_tb.sv
module paged_window_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_stb = 1'b0, up_we = 1'b0;
  logic [15:0] up_adr = '0;
  logic [31:0] up_wdata = '0;
  logic [3:0]  up_sel = '0;
  logic [31:0] up_rdata;
  logic        up_ack;
  logic        dn_cyc, dn_stb, dn_we;
  logic [31:0] dn_adr, dn_wdata;
  logic [3:0]  dn_sel;
  logic [31:0] dn_rdata = '0;
  logic        dn_ack = 1'b0;

  int checks = 0, failures = 0;
  int lat = 0;
  bit resp_en = 1'b1;
  int scnt = 0;
  int dn_edges = 0;
  logic [31:0] cap_adr, cap_dat;
  logic        cap_we;
  logic [3:0]  cap_sel;
  logic [31:0] page_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_window_bridge #(.TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_stb(up_stb), .up_we(up_we), .up_adr(up_adr),
    .up_wdata(up_wdata), .up_sel(up_sel), .up_rdata(up_rdata), .up_ack(up_ack),
    .dn_cyc(dn_cyc), .dn_stb(dn_stb), .dn_we(dn_we), .dn_adr(dn_adr),
    .dn_wdata(dn_wdata), .dn_sel(dn_sel), .dn_rdata(dn_rdata), .dn_ack(dn_ack)
  );

  function automatic logic [31:0] slv_data(input logic [31:0] a);
    return (a ^ 32'h5A5A_C3C3) + 32'h0000_1357;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      dn_ack <= 1'b0;
      scnt <= 0;
    end else begin
      if (dn_stb) dn_edges <= dn_edges + 1;
      if (dn_ack) dn_ack <= 1'b0;
      else if (dn_stb && resp_en) begin
        if (scnt >= lat) begin
          dn_ack   <= 1'b1;
          dn_rdata <= slv_data(dn_adr);
          cap_adr  <= dn_adr;
          cap_we   <= dn_we;
          cap_dat  <= dn_wdata;
          cap_sel  <= dn_sel;
          scnt     <= 0;
        end else scnt <= scnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [15:0] adr, input logic [31:0] dat,
                        input logic [3:0] sel, output logic [31:0] rd, output int wait_cyc);
    @(negedge clk);
    up_stb = 1'b1; up_we = we; up_adr = adr; up_wdata = dat; up_sel = sel;
    wait_cyc = 0;
    do begin
      @(negedge clk);
      wait_cyc++;
    end while (!up_ack && wait_cyc < 1000);
    rd = up_rdata;
    up_stb = 1'b0;
    @(negedge clk);
    chk(up_ack == 1'b0, "R7 ack pulse", {31'd0, up_ack}, 32'd0);
  endtask

  task automatic page_op(input bit we, input logic [31:0] dat);
    logic [31:0] rd;
    int w, e0;
    e0 = dn_edges;
    access(we, {1'b0, 15'($urandom)}, dat, 4'hF, rd, w);
    chk(w == 1, "R3 page ack latency", w, 1);
    chk(dn_edges == e0, "R3 no downstream cycle", dn_edges - e0, 0);
    chk(rd == page_m, "R2 page readback", rd, page_m);
    if (we) page_m = dat & 32'hFFFF_8000;
  endtask

  task automatic win_op(input bit we, input logic [14:0] off, input logic [31:0] dat, input logic [3:0] sel);
    logic [31:0] rd, ea;
    int w;
    ea = page_m | {17'd0, off};
    access(we, {1'b1, off}, dat, sel, rd, w);
    chk(cap_adr == ea, "R4 downstream address", cap_adr, ea);
    chk(cap_we == we, "R5 direction", {31'd0, cap_we}, {31'd0, we});
    if (we) begin
      chk(cap_dat == dat, "R5 write data", cap_dat, dat);
      chk(cap_sel == sel, "R5 byte selects", {28'd0, cap_sel}, {28'd0, sel});
    end else begin
      chk(rd == slv_data(ea), "R6 read data", rd, slv_data(ea));
    end
    chk(dn_cyc == 1'b0, "R7 downstream idle after ack", {31'd0, dn_cyc}, 32'd0);
  endtask

  task automatic tmo_op(input bit we, input logic [14:0] off);
    logic [31:0] rd;
    int w, e0;
    resp_en = 1'b0;
    e0 = dn_edges;
    access(we, {1'b1, off}, 32'h1234_5678, 4'h3, rd, w);
    chk(dn_edges - e0 == TMO, "R8 timeout length", dn_edges - e0, TMO);
    chk(rd == 32'hFFFF_FFFF, "R8 timeout data", rd, 32'hFFFF_FFFF);
    chk(dn_cyc == 1'b0, "R8 cycle dropped", {31'd0, dn_cyc}, 32'd0);
    resp_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(up_ack == 1'b0 && dn_cyc == 1'b0, "R1 reset outputs", {30'd0, up_ack, dn_cyc}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    page_op(1'b0, 32'd0);                         // R1 page reads zero
    page_op(1'b1, 32'hFFFF_FFFF);                 // R2 low bits masked
    page_op(1'b0, 32'd0);
    win_op(1'b0, 15'h7FFF, 32'd0, 4'hF);          // R4 top offset
    page_op(1'b1, 32'h3303_1004);
    win_op(1'b1, 15'h0000, 32'hDEAD_BEEF, 4'h5);  // R5 write, bottom offset
    win_op(1'b0, 15'h1020, 32'd0, 4'hF);          // R6
    tmo_op(1'b0, 15'h0010);                       // R8 read timeout
    tmo_op(1'b1, 15'h0044);                       // R8 write timeout
    win_op(1'b0, 15'h0004, 32'd0, 4'hF);          // recovery after timeout
    for (int i = 0; i < 60; i++) begin
      lat = int'($urandom_range(0, 4));
      case ($urandom_range(0, 3))
        0: page_op(1'b1, $urandom);
        1: page_op(1'b0, 32'd0);
        2: win_op(1'b1, 15'($urandom), $urandom, 4'($urandom));
        default: win_op(1'b0, 15'($urandom), 32'd0, 4'hF);
      endcase
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule